// File: doc/BRIEF.md
# Direct-Mapped Cache Tag Store with Hit Compare

This block holds the tag directory of a direct-mapped cache. Each line stores a tag field and three status bits. An index selects one line. The stored tag and status of that line appear combinationally on the outputs. At the same time the stored tag is compared with the tag presented on the input bus, so a hit flag is available in the same cycle as the address.

Tag and status are written on the rising clock edge, each under its own enable. An active-low flush input, sampled on a rising edge, clears the status bits of every line in a single cycle and leaves the tags alone.

A mode input decides how the status bits are used:
- In fixed mode, bit 0 is valid, bit 1 is dirty and bit 2 is write-through, and the block uses valid and write-through internally.
- In generic mode, the three bits are plain user storage.

Two chip selects gate all writes and the hit flag. A built-in active-low transfer acknowledge combines the hit, the access direction, the write-through bit and a few external controls.

Top module: `cache_tag_cmp`

## Requirements
- R1: `tag_out` and `stat_out` show the stored tag and status of the line addressed by `idx` combinationally. The line is the one as it stands after the most recent clock edge.
- R2: `hit` is high only when the stored tag of the addressed line equals `tag_in`. A tag that differs in any bit gives `hit` low.
- R3: Status encoding: bit 0 is valid, bit 1 is dirty and bit 2 is write-through. In fixed mode (`generic_mode` = 0), `hit` also requires the stored valid bit to be set.
- R4: `tag_we` writes only the tag and `stat_we` writes only the status of the addressed line. The other field keeps its value.
- R5: A rising edge with `flush_n` low clears all three status bits of every line. All stored tags keep their values.
- R6: When `flush_n` is low and a status write happens on the same edge, the flush wins and the status ends up zero.
- R7: In generic mode (`generic_mode` = 1), `hit` is the plain tag comparison. The write-through bit has no effect on the acknowledge.
- R8: The block is selected only when `cs_a_n` = 0 and `cs_b` = 1. When it is not selected, no edge writes tag or status, `hit` is low and `ack_n` is high.
- R9: `ack_n` goes low on a hit with `rd_wr` = 1 (read). On a hit with `rd_wr` = 0 (write), it goes low only if the stored write-through bit is clear (fixed mode).
- R10: A low on `ack_ext_n` drives `ack_n` low while the block is selected, regardless of the hit.
- R11: `ack_force_hi` = 1 or `ack_oe` = 0 holds `ack_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| flush_n | input | 1 | Synchronous active-low clear of all status bits |
| idx | input | IDX_W | Line index |
| tag_in | input | TAG_W | Tag for compare and write |
| stat_in | input | 3 | Status write data (bit0 valid, bit1 dirty, bit2 write-through) |
| tag_we | input | 1 | Tag write enable |
| stat_we | input | 1 | Status write enable |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| generic_mode | input | 1 | 1: status bits are user bits |
| rd_wr | input | 1 | Access direction, 1 = read |
| ack_force_hi | input | 1 | Forces acknowledge inactive |
| ack_oe | input | 1 | Acknowledge output enable |
| ack_ext_n | input | 1 | External acknowledge request, active low |
| tag_out | output | TAG_W | Stored tag of addressed line |
| stat_out | output | 3 | Stored status of addressed line |
| hit | output | 1 | Qualified tag match |
| ack_n | output | 1 | Transfer acknowledge, active low |

## Verification
The in-module assertions check several rules on every cycle:
- a fixed-mode hit always has the valid bit set;
- a deselected block shows no hit and no acknowledge;
- force-high and a disabled acknowledge keep `ack_n` high;
- a flush leaves the status at zero on the next cycle;
- a tag write lands on its line;
- a deselected edge leaves the addressed line unchanged.

Only the bench scenarios can show the remaining behaviour. That covers that each write enable leaves the other field intact and that a flush reaches lines other than the one addressed while sparing the tags. It also covers the read and write acknowledge rules with the write-through bit in both modes, and that the external request drives the acknowledge.

// File: rtl/cache_tag_cmp.sv
module cache_tag_cmp #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             flush_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag_in,
  input  logic [2:0]       stat_in,
  input  logic             tag_we,
  input  logic             stat_we,
  input  logic             cs_a_n,
  input  logic             cs_b,
  input  logic             generic_mode,
  input  logic             rd_wr,
  input  logic             ack_force_hi,
  input  logic             ack_oe,
  input  logic             ack_ext_n,
  output logic [TAG_W-1:0] tag_out,
  output logic [2:0]       stat_out,
  output logic             hit,
  output logic             ack_n
);
  localparam int LINES  = 1 << IDX_W;
  localparam int B_VLD  = 0;
  localparam int B_WT   = 2;

  logic [TAG_W-1:0] tag_mem  [LINES];
  logic [2:0]       stat_mem [LINES];

  logic sel, tag_eq, vld_ok, wt_blocks, ack_want;

  assign sel = ~cs_a_n & cs_b;

  always_ff @(posedge clk)
    if (sel && tag_we) tag_mem[idx] <= tag_in;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk)
      if (!flush_n)
        stat_mem[i] <= '0;
      else if (sel && stat_we && idx == IDX_W'(i))
        stat_mem[i] <= stat_in;
  end

  assign tag_out   = tag_mem[idx];
  assign stat_out  = stat_mem[idx];
  assign tag_eq    = (tag_out == tag_in);
  assign vld_ok    = generic_mode | stat_out[B_VLD];
  assign hit       = sel & tag_eq & vld_ok;
  assign wt_blocks = ~generic_mode & stat_out[B_WT];
  assign ack_want  = ~ack_ext_n | (hit & (rd_wr | ~wt_blocks));
  assign ack_n     = ~(sel & ack_oe & ~ack_force_hi & ack_want);

  assert_hit_needs_valid_R3: assert property (@(posedge clk) disable iff (!flush_n)
    (hit && !generic_mode) |-> stat_out[B_VLD]);

  assert_deselect_quiet_R8: assert property (@(posedge clk) disable iff (!flush_n)
    !(~cs_a_n & cs_b) |-> (!hit && ack_n));

  assert_deselect_no_write_R8: assert property (@(posedge clk) disable iff (!flush_n)
    !(~cs_a_n & cs_b) |=> (idx != $past(idx)) || (tag_out == $past(tag_out)));

  assert_ack_blocked_R11: assert property (@(posedge clk) disable iff (!flush_n)
    (ack_force_hi || !ack_oe) |-> ack_n);

  assert_tag_write_lands_R4: assert property (@(posedge clk) disable iff (!flush_n)
    (!cs_a_n && cs_b && tag_we) |=> (idx != $past(idx)) || (tag_out == $past(tag_in)));

  assert_flush_clears_R5: assert property (@(posedge clk)
    !flush_n |=> (stat_out == 3'b000));
endmodule

// File: tb/cache_tag_cmp_tb_top.sv
module cache_tag_cmp_tb_top;
  localparam int IW = 6;
  localparam int TW = 12;
  localparam int N  = 1 << IW;

  logic clk = 0;
  always #2 clk = ~clk;

  logic          flush_n = 0, tag_we = 0, stat_we = 0, cs_a_n = 1, cs_b = 0;
  logic          generic_mode = 0, rd_wr = 1, ack_force_hi = 0, ack_oe = 1, ack_ext_n = 1;
  logic [IW-1:0] idx = '0;
  logic [TW-1:0] tag_in = '0;
  logic [2:0]    stat_in = '0;
  logic [TW-1:0] tag_out;
  logic [2:0]    stat_out;
  logic          hit, ack_n;

  cache_tag_cmp #(.IDX_W(IW), .TAG_W(TW)) dut_i (
    .clk(clk), .flush_n(flush_n), .idx(idx), .tag_in(tag_in), .stat_in(stat_in),
    .tag_we(tag_we), .stat_we(stat_we), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .generic_mode(generic_mode), .rd_wr(rd_wr), .ack_force_hi(ack_force_hi),
    .ack_oe(ack_oe), .ack_ext_n(ack_ext_n), .tag_out(tag_out), .stat_out(stat_out),
    .hit(hit), .ack_n(ack_n));

  typedef struct {
    logic          h;
    logic          a;
    logic [TW-1:0] t;
    logic [2:0]    s;
    bit            kt;
    bit            ks;
    string         req;
  } exp_t;

  exp_t          sb[$];
  logic [TW-1:0] m_tag [N];
  logic [2:0]    m_stat [N];
  bit            m_tag_ok [N];
  bit            m_stat_ok = 0;
  int            n_run = 0, n_fail = 0;
  bit            done = 0;

  // staged inputs for the next step
  logic          x_fl = 0, x_twe = 0, x_swe = 0, x_ca = 1, x_cb = 0, x_gen = 0, x_rw = 1;
  logic          x_fh = 0, x_oe = 1, x_ext = 1;
  logic [IW-1:0] x_idx = '0;
  logic [TW-1:0] x_tag = '0;
  logic [2:0]    x_st = '0;

  task automatic step(input string req);
    exp_t e;
    logic sel, h, want;
    @(negedge clk);
    flush_n = x_fl; tag_we = x_twe; stat_we = x_swe; cs_a_n = x_ca; cs_b = x_cb;
    generic_mode = x_gen; rd_wr = x_rw; ack_force_hi = x_fh; ack_oe = x_oe;
    ack_ext_n = x_ext; idx = x_idx; tag_in = x_tag; stat_in = x_st;
    sel  = !x_ca && x_cb;
    h    = sel && m_tag_ok[x_idx] && m_stat_ok && (m_tag[x_idx] == x_tag)
           && (x_gen || m_stat[x_idx][0]);
    want = !x_ext || (h && (x_rw || x_gen || !m_stat[x_idx][2]));
    e.h = h; e.a = !(sel && x_oe && !x_fh && want);
    e.t = m_tag[x_idx]; e.s = m_stat[x_idx];
    e.kt = m_tag_ok[x_idx]; e.ks = m_stat_ok; e.req = req;
    sb.push_back(e);
    @(posedge clk);
    if (sel && x_twe) begin m_tag[x_idx] = x_tag; m_tag_ok[x_idx] = 1; end
    if (!x_fl) begin
      for (int i = 0; i < N; i++) m_stat[i] = '0;
      m_stat_ok = 1;
    end else if (sel && x_swe) m_stat[x_idx] = x_st;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_run++;
        if (hit !== e.h || ack_n !== e.a || (e.kt && tag_out !== e.t) || (e.ks && stat_out !== e.s)) begin
          n_fail++;
          $display("FAIL %s: hit/ack/tag/stat got %b/%b/%h/%b exp %b/%b/%h/%b",
                   e.req, hit, ack_n, tag_out, stat_out, e.h, e.a, e.t, e.s);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_tag_ok[i] = 0; m_tag[i] = '0; m_stat[i] = '0; end
    step("R8 reset, deselected");
    step("R5 flush state");
    x_fl = 1; x_ca = 0; x_cb = 1;
    x_idx = 5; x_tag = 12'hABC; x_st = 3'b001; x_twe = 1; x_swe = 1;
    step("R1 write line 5");
    x_twe = 0; x_swe = 0;
    step("R2 R9 read hit");
    x_tag = 12'hABD;
    step("R2 one-bit tag mismatch");
    x_tag = 12'h123; x_st = 3'b000; x_swe = 1;
    step("R4 status-only write");
    x_swe = 0; x_tag = 12'hABC;
    step("R3 valid clear, no hit");
    x_gen = 1;
    step("R7 generic mode hit without valid");
    x_gen = 0; x_st = 3'b101; x_swe = 1;
    step("R4 status write valid+wt");
    x_swe = 0; x_twe = 1; x_tag = 12'h555;
    step("R4 tag-only write");
    x_twe = 0;
    step("R4 R9 read after tag write keeps status");
    x_rw = 0;
    step("R9 write access with wt set, no ack");
    x_gen = 1;
    step("R7 generic mode ignores wt");
    x_gen = 0; x_st = 3'b001; x_swe = 1;
    step("R9 clear wt");
    x_swe = 0;
    step("R9 write access with wt clear acks");
    x_fh = 1;
    step("R11 force high");
    x_fh = 0; x_oe = 0;
    step("R11 output enable off");
    x_oe = 1; x_rw = 1; x_tag = 12'h000; x_ext = 0;
    step("R10 external ack on miss");
    x_cb = 0; x_twe = 1; x_swe = 1; x_st = 3'b111; x_tag = 12'h777;
    step("R8 cs_b inactive");
    x_cb = 1; x_ca = 1;
    step("R8 cs_a_n inactive");
    x_ca = 0; x_twe = 0; x_swe = 0; x_ext = 1; x_tag = 12'h555;
    step("R8 line unchanged after deselected writes");
    x_idx = 9; x_tag = 12'h0F0; x_st = 3'b001; x_twe = 1; x_swe = 1;
    step("R1 write line 9");
    x_idx = 5; x_twe = 0; x_st = 3'b111; x_fl = 0; x_tag = 12'h555;
    step("R6 flush with status write");
    x_fl = 1; x_swe = 0;
    step("R6 R5 status zero, tag kept");
    x_idx = 9; x_tag = 12'h0F0;
    step("R5 other line flushed");
    x_gen = 1;
    step("R7 R5 generic hit on flushed line");
    @(negedge clk); #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule